// File: doc/BRIEF.md
# SDRAM Command Bus Monitor

This block watches the command pins of a single-data-rate SDRAM bus and names the command the memory sees on every clock edge. It takes the clock enable of the previous edge together with the current one into account. This lets it tell an ordinary command apart from the cycles that enter or leave self-refresh, precharge power-down, or clock suspend (also called active power-down), and from the frozen cycles in between. Alongside the decoded command it keeps a model of every bank (idle, open, precharging) and of the device power state.

It sits passively beside a controller, either in a testbench or as an on-chip checker. It raises one-cycle error pulses when the command stream breaks the ordering rules of a bank, violates a minimum gap between commands, issues a mode or refresh command while banks are not idle, or issues a command too soon after a mode register write or a clock-enable transition. Data and electrical timing are not examined.

All outputs are registered. The values visible after a rising edge describe the command sampled at that edge.

Top module: `sdr_cmd_monitor`

## Requirements
- R1: While reset is applied, and until a command is sampled, cmd_code reads 0, pwr_state reads 0 (running), every bank field reads 0 (idle) and all four error outputs are low.
- R2: With clock enable high on both the previous and the current edge and chip select low, {ras_n,cas_n,we_n} decodes as 000 mode write (code 2), 001 auto-refresh (3), 011 activate (4), 101 read (5), 100 write (6), 110 burst stop (7), 010 precharge (8), 111 no operation (0). With chip select high the code is deselect (1). Each code appears on cmd_code after the edge that sampled it.
- R3: The bank is selected by the bank bits read in reverse order, so ba values 00, 10, 01, 11 address banks 0, 1, 2, 3. Bank i reports on bank_state[2i+1:2i]. A precharge with a10 high is decoded as precharge-all (code 9) and ignores ba.
- R4: A bank field reads 0 idle, 1 open or 2 precharging. An activate opens an idle bank. A precharge moves an open bank to precharging, and the bank returns to idle T_RP edges after the precharge. Precharging an idle bank leaves it idle.
- R5: err_order pulses for a read or write to a bank that is not open, and for an activate to a bank that is already open.
- R6: err_timing pulses for a read or write fewer than T_RCD edges after that bank's activate, a precharge of an open bank fewer than T_RAS edges after its activate, or an activate to a bank still precharging, that is fewer than T_RP edges after its precharge. A gap of exactly the parameter value is legal.
- R7: err_mode pulses when a mode write, auto-refresh or self-refresh entry is sampled while any bank is not idle.
- R8: err_mode pulses when a pin pattern other than no operation or deselect is sampled within MRS_GAP-1 edges after a mode write.
- R9: When clock enable falls (high then low), the edge is decoded as self-refresh entry (10) if the pins carry auto-refresh. Otherwise it is clock-suspend entry (14) if any bank is open, or power-down entry (12). pwr_state then reads 1, 3 or 2 respectively. While clock enable stays low the code is hold (16). When it rises, the code is the matching exit (11, 15 or 13) and pwr_state returns to 0.
- R10: err_cke pulses when the edge on which clock enable rises carries a pattern other than no operation or deselect. It also pulses when the edge on which clock enable falls carries such a pattern other than auto-refresh.
- R11: Pin patterns sampled while the previous clock enable was low are not executed: bank states do not change and no order, timing or mode error follows from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10 (all-banks select on precharge) |
| ba | input | BA_W | Bank bits |
| cmd_code | output | 5 | Decoded command of the last sampled edge |
| pwr_state | output | 2 | 0 running, 1 self-refresh, 2 power-down, 3 clock suspend |
| bank_state | output | 2*2**BA_W | Two-bit state per bank |
| err_order | output | 1 | Bank ordering violation |
| err_timing | output | 1 | Minimum-gap violation |
| err_mode | output | 1 | Mode or refresh rule violation |
| err_cke | output | 1 | Command on a clock-enable transition |

## Verification
The assertions check every cycle that an open bank stays open unless a precharge addresses it, and that no bank opens without an activate. They also check that the power state cannot change while clock enable stays low, that it stays running while clock enable stays high, and that a hold code is never reported in the running state. The exact decode table, the bank-bit reversal, the boundary gaps of T_RCD, T_RAS, T_RP and the mode-write window, and the choice between suspend, power-down and self-refresh on a falling clock enable are only shown by the bench's scripted command streams. The bench compares the code, power state, bank fields and error pulses after each edge.

// File: rtl/sdr_mon_pkg.sv
package sdr_mon_pkg;

  typedef enum logic [4:0] {
    C_NOP      = 5'd0,
    C_DESEL    = 5'd1,
    C_MRS      = 5'd2,
    C_AREF     = 5'd3,
    C_ACT      = 5'd4,
    C_RD       = 5'd5,
    C_WR       = 5'd6,
    C_BST      = 5'd7,
    C_PRE      = 5'd8,
    C_PREA     = 5'd9,
    C_SREF_IN  = 5'd10,
    C_SREF_OUT = 5'd11,
    C_PDN_IN   = 5'd12,
    C_PDN_OUT  = 5'd13,
    C_SUSP_IN  = 5'd14,
    C_SUSP_OUT = 5'd15,
    C_HOLD     = 5'd16
  } cmd_e;

  typedef enum logic [1:0] {
    P_RUN  = 2'd0,
    P_SREF = 2'd1,
    P_PDN  = 2'd2,
    P_SUSP = 2'd3
  } pwr_e;

  typedef enum logic [1:0] {
    B_IDLE  = 2'd0,
    B_OPEN  = 2'd1,
    B_PRECH = 2'd2
  } bank_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  input  pwr_e pwr,
  input  logic any_open,
  output cmd_e cmd,
  output logic quiet
);

  cmd_e pin_cmd;

  // Pattern carried by the pins, ignoring clock enable
  always_comb begin
    if (cs_n) begin
      pin_cmd = C_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  pin_cmd = C_MRS;
        3'b001:  pin_cmd = C_AREF;
        3'b011:  pin_cmd = C_ACT;
        3'b101:  pin_cmd = C_RD;
        3'b100:  pin_cmd = C_WR;
        3'b110:  pin_cmd = C_BST;
        3'b010:  pin_cmd = a10 ? C_PREA : C_PRE;
        default: pin_cmd = C_NOP;
      endcase
    end
  end

  assign quiet = cs_n | (ras_n & cas_n & we_n);

  // Clock-enable history selects between command, entry, exit and hold
  always_comb begin
    case ({cke_prev, cke})
      2'b11: cmd = pin_cmd;
      2'b10: begin
        if (pin_cmd == C_AREF) cmd = C_SREF_IN;
        else if (any_open)     cmd = C_SUSP_IN;
        else                   cmd = C_PDN_IN;
      end
      2'b01: begin
        case (pwr)
          P_SREF:  cmd = C_SREF_OUT;
          P_PDN:   cmd = C_PDN_OUT;
          default: cmd = C_SUSP_OUT;
        endcase
      end
      default: cmd = C_HOLD;
    endcase
  end

endmodule

// File: rtl/sdr_power_track.sv
module sdr_power_track
  import sdr_mon_pkg::*;
#(
  parameter int MRS_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  cmd_e cmd,
  input  logic quiet,
  input  logic all_idle,
  output logic cke_prev_q,
  output pwr_e pwr_q,
  output logic err_mode_nx,
  output logic err_cke_nx
);

  localparam int GAP_W = $clog2(MRS_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(MRS_GAP > 1 ? MRS_GAP - 1 : 0);

  pwr_e             pwr_nx;
  logic [GAP_W-1:0] wait_q, wait_nx;

  always_comb begin
    pwr_nx = pwr_q;
    case (cmd)
      C_SREF_IN:  pwr_nx = P_SREF;
      C_PDN_IN:   pwr_nx = P_PDN;
      C_SUSP_IN:  pwr_nx = P_SUSP;
      C_SREF_OUT,
      C_PDN_OUT,
      C_SUSP_OUT: pwr_nx = P_RUN;
      default:    pwr_nx = pwr_q;
    endcase
  end

  always_comb begin
    if (cmd == C_MRS)      wait_nx = GAP_LOAD;
    else if (wait_q != '0) wait_nx = wait_q - 1'b1;
    else                   wait_nx = wait_q;
  end

  always_comb begin
    err_mode_nx = ((cmd == C_MRS || cmd == C_AREF || cmd == C_SREF_IN) && !all_idle)
                || (wait_q != '0 && !quiet);
    err_cke_nx  = (!cke_prev_q && cke && !quiet)
                || (cke_prev_q && !cke && !quiet && cmd != C_SREF_IN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b1;
      pwr_q      <= P_RUN;
      wait_q     <= '0;
    end else begin
      cke_prev_q <= cke;
      pwr_q      <= pwr_nx;
      wait_q     <= wait_nx;
    end
  end

  // R9
  frozen_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_prev_q && !cke) |=> $stable(pwr_q));

  // R9
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q == P_RUN && cke_prev_q && cke) |=> (pwr_q == P_RUN));

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
  import sdr_mon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RAS = 7,
  parameter int T_RP  = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_e  cmd,
  input  logic  hit,
  output bank_e st_q,
  output logic  err_order_nx,
  output logic  err_timing_nx
);

  localparam int MAX_T = (T_RAS > T_RCD) ? ((T_RAS > T_RP) ? T_RAS : T_RP)
                                         : ((T_RCD > T_RP) ? T_RCD : T_RP);
  localparam int AGE_W = $clog2(MAX_T + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MAX_T);
  localparam logic [AGE_W-1:0] RCD_L   = AGE_W'(T_RCD);
  localparam logic [AGE_W-1:0] RAS_L   = AGE_W'(T_RAS);
  localparam logic [AGE_W-1:0] RP_L    = AGE_W'(T_RP);

  bank_e            st_nx;
  logic [AGE_W-1:0] age_q, age_nx, age_inc;
  logic             is_act, is_rw, is_pre;

  assign is_act  = (cmd == C_ACT) && hit;
  assign is_rw   = ((cmd == C_RD) || (cmd == C_WR)) && hit;
  assign is_pre  = ((cmd == C_PRE) && hit) || (cmd == C_PREA);
  assign age_inc = (age_q == AGE_MAX) ? age_q : age_q + 1'b1;

  always_comb begin
    err_order_nx  = (is_rw && st_q != B_OPEN) || (is_act && st_q == B_OPEN);
    err_timing_nx = (is_rw  && st_q == B_OPEN && age_q < RCD_L)
                 || (is_pre && st_q == B_OPEN && age_q < RAS_L)
                 || (is_act && st_q == B_PRECH);
  end

  always_comb begin
    st_nx  = st_q;
    age_nx = age_inc;
    case (st_q)
      B_IDLE: begin
        if (is_act) begin
          st_nx  = B_OPEN;
          age_nx = AGE_W'(1);
        end
      end
      B_OPEN: begin
        if (is_pre) begin
          st_nx  = (T_RP <= 1) ? B_IDLE : B_PRECH;
          age_nx = AGE_W'(1);
        end
      end
      B_PRECH: begin
        if (is_act) begin
          st_nx  = B_OPEN;
          age_nx = AGE_W'(1);
        end else if (age_inc >= RP_L) begin
          st_nx = B_IDLE;
        end
      end
      default: st_nx = B_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      age_q <= '0;
    end else begin
      st_q  <= st_nx;
      age_q <= age_nx;
    end
  end

  // R4
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == B_OPEN && !((cmd == C_PRE) && hit) && cmd != C_PREA) |=> (st_q == B_OPEN));

  // R4
  open_by_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != B_OPEN && !((cmd == C_ACT) && hit)) |=> (st_q != B_OPEN));

endmodule

// File: rtl/sdr_cmd_monitor.sv
module sdr_cmd_monitor
  import sdr_mon_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 7,
  parameter int T_RP    = 3,
  parameter int MRS_GAP = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    a10,
  input  logic [BA_W-1:0]         ba,
  output logic [4:0]              cmd_code,
  output logic [1:0]              pwr_state,
  output logic [2*(1<<BA_W)-1:0]  bank_state,
  output logic                    err_order,
  output logic                    err_timing,
  output logic                    err_mode,
  output logic                    err_cke
);

  localparam int NB = 1 << BA_W;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [BA_W-1:0] bank_idx;
  logic [NB-1:0]   open_v, idle_v, ord_v, tim_v;
  logic            any_open, all_idle;
  logic            cke_prev;
  logic            mode_nx, cke_err_nx;
  pwr_e            pwr;
  cmd_e            cmd, cmd_q;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Bank bits are read in reverse order
  always_comb begin
    for (int i = 0; i < BA_W; i++) bank_idx[i] = ba[BA_W-1-i];
  end

  sdr_cmd_decode i_decode (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .pwr      (pwr),
    .any_open (any_open),
    .cmd      (cmd),
    .quiet    (quiet)
  );

  logic quiet;

  sdr_power_track #(.MRS_GAP(MRS_GAP)) i_power (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cke         (cke),
    .cmd         (cmd),
    .quiet       (quiet),
    .all_idle    (all_idle),
    .cke_prev_q  (cke_prev),
    .pwr_q       (pwr),
    .err_mode_nx (mode_nx),
    .err_cke_nx  (cke_err_nx)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bank_e st;
    sdr_bank_fsm #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) i_bank (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .cmd           (cmd),
      .hit           (bank_idx == BA_W'(g)),
      .st_q          (st),
      .err_order_nx  (ord_v[g]),
      .err_timing_nx (tim_v[g])
    );
    assign open_v[g]           = (st == B_OPEN);
    assign idle_v[g]           = (st == B_IDLE);
    assign bank_state[2*g +: 2] = st;
  end

  assign any_open = |open_v;
  assign all_idle = &idle_v;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q      <= C_NOP;
      err_order  <= 1'b0;
      err_timing <= 1'b0;
      err_mode   <= 1'b0;
      err_cke    <= 1'b0;
    end else begin
      cmd_q      <= cmd;
      err_order  <= |ord_v;
      err_timing <= |tim_v;
      err_mode   <= mode_nx;
      err_cke    <= cke_err_nx;
    end
  end

  assign cmd_code  = cmd_q;
  assign pwr_state = pwr;

  // R11
  hold_not_run_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_q == C_HOLD) |-> (pwr != P_RUN));

endmodule

// File: tb/test_sdr_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdr_cmd_monitor;

  logic       clk = 1'b0;
  logic       rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] ba;
  logic [4:0] cmd_code;
  logic [1:0] pwr_state;
  logic [7:0] bank_state;
  logic       err_order, err_timing, err_mode, err_cke;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdr_cmd_monitor i_sdr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba),
    .cmd_code(cmd_code), .pwr_state(pwr_state), .bank_state(bank_state),
    .err_order(err_order), .err_timing(err_timing), .err_mode(err_mode),
    .err_cke(err_cke)
  );

  // pin patterns {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PN = 4'b0111, PD = 4'b1111, PM = 4'b0000, PF = 4'b0001;
  localparam logic [3:0] PA = 4'b0011, PR = 4'b0101, PW = 4'b0100, PB = 4'b0110;
  localparam logic [3:0] PP = 4'b0010;
  // bank bits for banks 0..3 (R3)
  localparam logic [1:0] B0 = 2'b00, B1 = 2'b10, B2 = 2'b01, B3 = 2'b11;

  typedef struct {
    logic [4:0] cmd;
    logic [1:0] pwr;
    logic [7:0] banks;
    logic [3:0] err;
    string      tag;
  } exp_t;

  exp_t sb[$];
  exp_t e;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] pins, input logic a, input logic [1:0] b,
                      input logic [4:0] ec, input logic [1:0] ep, input logic [7:0] eb,
                      input logic [3:0] ee, input string tag);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = pins;
    a10 = a;
    ba  = b;
    sb.push_back('{ec, ep, eb, ee, tag});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // monitor: compare one expected item per edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      chk(e.tag, "cmd_code", 32'(cmd_code), 32'(e.cmd));
      chk(e.tag, "pwr_state", 32'(pwr_state), 32'(e.pwr));
      chk(e.tag, "bank_state", 32'(bank_state), 32'(e.banks));
      chk(e.tag, "errors{order,timing,mode,cke}",
          32'({err_order, err_timing, err_mode, err_cke}), 32'(e.err));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = PN; a10 = 1'b0; ba = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset cmd_code", 32'(cmd_code), 32'd0);
    chk("R1", "reset pwr_state", 32'(pwr_state), 32'd0);
    chk("R1", "reset bank_state", 32'(bank_state), 32'd0);
    chk("R1", "reset errors", 32'({err_order, err_timing, err_mode, err_cke}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(1, PN, 0, B0,  0, 0, 8'h00, 4'b0000, "R1");
    step(1, PD, 0, B0,  1, 0, 8'h00, 4'b0000, "R2");
    step(1, PM, 0, B0,  2, 0, 8'h00, 4'b0000, "R2");
    step(1, PN, 0, B0,  0, 0, 8'h00, 4'b0000, "R8");
    step(1, PF, 0, B0,  3, 0, 8'h00, 4'b0000, "R2");
    step(1, PM, 0, B0,  2, 0, 8'h00, 4'b0000, "R2");
    step(1, PA, 0, B0,  4, 0, 8'h01, 4'b0010, "R8");   // activate one edge after mode write
    step(1, PR, 0, B0,  5, 0, 8'h01, 4'b0100, "R6");   // read gap 1
    step(1, PN, 0, B0,  0, 0, 8'h01, 4'b0000, "R2");
    step(1, PW, 0, B0,  6, 0, 8'h01, 4'b0000, "R6");   // write gap exactly T_RCD
    step(1, PB, 0, B0,  7, 0, 8'h01, 4'b0000, "R2");
    step(1, PR, 0, B1,  5, 0, 8'h01, 4'b1000, "R5");   // read to idle bank 1
    step(1, PA, 0, B2,  4, 0, 8'h11, 4'b0000, "R3");   // ba=01 opens bank 2
    step(1, PA, 0, B2,  4, 0, 8'h11, 4'b1000, "R5");   // activate open bank
    step(1, PP, 0, B2,  8, 0, 8'h21, 4'b0100, "R6");   // precharge before T_RAS
    step(1, PF, 0, B0,  3, 0, 8'h21, 4'b0010, "R7");   // refresh with banks busy
    step(1, PN, 0, B0,  0, 0, 8'h01, 4'b0000, "R4");   // bank 2 idle after T_RP
    step(1, PA, 0, B2,  4, 0, 8'h11, 4'b0000, "R6");   // activate at exactly T_RP
    step(1, PP, 1, B3,  9, 0, 8'h22, 4'b0100, "R3");   // precharge all
    step(1, PA, 0, B3,  4, 0, 8'h62, 4'b0000, "R4");
    step(1, PR, 0, B3,  5, 0, 8'h40, 4'b0100, "R6");
    step(0, PN, 0, B0, 14, 3, 8'h40, 4'b0000, "R9");   // suspend entry, bank open
    step(0, PR, 0, B0, 16, 3, 8'h40, 4'b0000, "R11");  // frozen read ignored
    step(1, PN, 0, B0, 15, 0, 8'h40, 4'b0000, "R9");
    step(1, PN, 0, B0,  0, 0, 8'h40, 4'b0000, "R4");
    step(1, PN, 0, B0,  0, 0, 8'h40, 4'b0000, "R4");
    step(1, PP, 0, B3,  8, 0, 8'h80, 4'b0000, "R6");   // precharge at exactly T_RAS
    step(1, PA, 0, B3,  4, 0, 8'h40, 4'b0100, "R6");   // activate while precharging
    step(1, PP, 0, B3,  8, 0, 8'h80, 4'b0100, "R6");
    step(1, PN, 0, B0,  0, 0, 8'h80, 4'b0000, "R4");
    step(1, PN, 0, B0,  0, 0, 8'h00, 4'b0000, "R4");
    step(0, PF, 0, B0, 10, 1, 8'h00, 4'b0000, "R9");   // self-refresh entry
    step(0, PN, 0, B0, 16, 1, 8'h00, 4'b0000, "R9");
    step(1, PA, 0, B0, 11, 0, 8'h00, 4'b0001, "R10");  // command on exit edge, not executed
    step(0, PR, 0, B0, 12, 2, 8'h00, 4'b0001, "R10");  // power-down entry with command
    step(0, PN, 0, B0, 16, 2, 8'h00, 4'b0000, "R11");
    step(1, PD, 0, B0, 13, 0, 8'h00, 4'b0000, "R9");
    step(1, PA, 0, B0,  4, 0, 8'h01, 4'b0000, "R2");
    step(1, PM, 0, B0,  2, 0, 8'h01, 4'b0010, "R7");   // mode write with open bank
    step(1, PN, 0, B0,  0, 0, 8'h01, 4'b0000, "R8");
    step(1, PB, 0, B0,  7, 0, 8'h01, 4'b0000, "R8");   // legal after MRS_GAP

    @(negedge clk);
    cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = PN;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    summary();
    $finish;
  end

endmodule